// File: doc/BRIEF.md
# DMA Global Run Control

This block is the global run-control register of a multi-channel DMA controller. It holds a master run enable and two sticky halt flags. One flag records a non-maskable interrupt and the other records an address error. It merges this global state with each channel's own enable (DE) and transfer-end (TE) status. The result is a registered "transfer permitted" strobe per channel and a combinational global suspend.

Software reaches the register through a plain read/write port. The master enable is an ordinary read/write bit. A halt flag cannot be set from software, and it can be cleared only by a two-step handshake. Software must first read the register while the flag is 1, and its very next write must then carry 0 in that flag's position. Any write consumes the armed read, whatever data that write carries.

The per-channel DE and TE inputs come from channel registers outside this block. The permit outputs feed the channel transfer engines.

Top module: `dma_gctl`

## Requirements
- R1: After reset, the master enable and both halt flags are 0, every permit output is 0 and the suspend output is 1.
- R2: The register bits are laid out as follows. Bit 0 is the master enable, bit 1 is the NMI halt flag and bit 2 is the address-error halt flag. Read data always shows the current values, and a write loads bit 0 into the master enable on the following clock edge.
- R3: An NMI event sets the NMI halt flag on the next clock edge, whatever the state of the master enable or the channels.
- R4: Writing 1 to either flag position never sets that flag.
- R5: A halt flag clears only on a write with 0 in its position, and only when the previous read found that flag at 1 with no write in between. A write of 0 without such a read leaves the flag set. Any write, including one carrying 1 in the flag's position, consumes the armed read.
- R6: The address-error flag follows the same set and clear rules as the NMI flag. An address-error event in the same cycle as a valid clear wins, so the flag stays 1.
- R7: The suspend output is 1 whenever the master enable is 0 or either halt flag is 1, with no register delay after the register state changes.
- R8: Permit for channel i is registered one cycle after the condition is met. The condition is that suspend is 0, DE[i] is 1 and TE[i] is 0. Otherwise permit for channel i is 0 after that same one-cycle delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Register read strobe (arms flag clears) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 3 | Write data: bit0 enable, bit1 NMI flag, bit2 address-error flag |
| rd_data | output | 3 | Current register contents, same layout |
| nmi_evt | input | 1 | Non-maskable interrupt event pulse |
| addr_err_evt | input | 1 | Address-error event pulse |
| ch_de | input | NUM_CH | Per-channel enable bits |
| ch_te | input | NUM_CH | Per-channel transfer-end bits |
| ch_permit | output | NUM_CH | Registered per-channel transfer permit |
| dma_suspend | output | 1 | Global suspend |

## Verification
A wrong flag or arm state first appears at the ports as the wrong value of `rd_data` and `dma_suspend`, one edge after the write or event that caused it. One more edge later it appears as the wrong `ch_permit` pattern. Flag-clear faults hide until a write, so the bench walks writes with and without a preceding armed read. It also writes 1 over a flag, and it collides an event with a valid clear. Channel masking is checked with mixed DE/TE patterns so that a swapped or dropped term changes a specific bit.

// File: rtl/dma_gctl_pkg.sv
package dma_gctl_pkg;
   localparam int unsigned REG_W    = 3;
   localparam int unsigned BIT_RUN  = 0;
   localparam int unsigned BIT_NMI  = 1;
   localparam int unsigned BIT_AERR = 2;
   localparam int unsigned N_FLAGS  = 2;
   localparam int unsigned MAX_CH   = 32;
endpackage

// File: rtl/dma_gctl_flag.sv
module dma_gctl_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wbit_i,
   output logic flag_o
);
   logic flag_q;
   logic arm_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         if (evt_i)
            flag_q <= 1'b1;
         else if (wr_i && arm_q && !wbit_i)
            flag_q <= 1'b0;
         if (wr_i)
            arm_q <= 1'b0;
         else if (rd_i)
            arm_q <= flag_q;
      end
   end

   assign flag_o = flag_q;

   // R3
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> flag_q);
   // R4
   flag_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !evt_i) |=> !flag_q);
   // R5
   flag_clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(wr_i && arm_q && !wbit_i)) |=> flag_q);
endmodule

// File: rtl/dma_gctl_permit.sv
module dma_gctl_permit #(
   parameter int unsigned NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              suspend_i,
   input  logic [NUM_CH-1:0] de_i,
   input  logic [NUM_CH-1:0] te_i,
   output logic [NUM_CH-1:0] permit_o
);
   logic [NUM_CH-1:0] permit_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n)
            permit_q[c] <= 1'b0;
         else
            permit_q[c] <= !suspend_i && de_i[c] && !te_i[c];
      end

      // R8
      permit_te_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (te_i[c] || !de_i[c]) |=> !permit_q[c]);
   end

   assign permit_o = permit_q;

   // R7
   permit_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_i |=> (permit_q == '0));
endmodule

// File: rtl/dma_gctl.sv
module dma_gctl
   import dma_gctl_pkg::*;
#(
   parameter int unsigned NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   input  logic              nmi_evt,
   input  logic              addr_err_evt,
   input  logic [NUM_CH-1:0] ch_de,
   input  logic [NUM_CH-1:0] ch_te,
   output logic [NUM_CH-1:0] ch_permit,
   output logic              dma_suspend
);
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("dma_gctl: NUM_CH out of range");
   end

   logic                run_q;
   logic [N_FLAGS-1:0]  evt_vec;
   logic [N_FLAGS-1:0]  flag_vec;

   assign evt_vec = {addr_err_evt, nmi_evt};

   always_ff @(posedge clk) begin
      if (!rst_n)
         run_q <= 1'b0;
      else if (wr_en)
         run_q <= wr_data[BIT_RUN];
   end

   for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
      dma_gctl_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt_i  (evt_vec[f]),
         .rd_i   (rd_en),
         .wr_i   (wr_en),
         .wbit_i (wr_data[BIT_NMI+f]),
         .flag_o (flag_vec[f])
      );
   end

   assign dma_suspend = !run_q || (|flag_vec);

   always_comb begin
      rd_data           = '0;
      rd_data[BIT_RUN]  = run_q;
      rd_data[BIT_NMI]  = flag_vec[0];
      rd_data[BIT_AERR] = flag_vec[1];
   end

   dma_gctl_permit #(.NUM_CH(NUM_CH)) u_permit (
      .clk       (clk),
      .rst_n     (rst_n),
      .suspend_i (dma_suspend),
      .de_i      (ch_de),
      .te_i      (ch_te),
      .permit_o  (ch_permit)
   );

   // R2
   run_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data[BIT_RUN] == $past(wr_data[BIT_RUN])));
   // R6
   aerr_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err_evt |=> rd_data[BIT_AERR]);
endmodule

// File: tb/tb_dma_gctl.sv
module tb_dma_gctl;
   localparam int NCH = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           rd_en = 1'b0;
   logic           wr_en = 1'b0;
   logic [2:0]     wr_data = '0;
   logic [2:0]     rd_data;
   logic           nmi_evt = 1'b0;
   logic           addr_err_evt = 1'b0;
   logic [NCH-1:0] ch_de = '0;
   logic [NCH-1:0] ch_te = '0;
   logic [NCH-1:0] ch_permit;
   logic           dma_suspend;

   typedef struct {
      logic [2:0]     rd;
      logic [NCH-1:0] perm;
      logic           susp;
      string          tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk  = 0;
   int   n_fail = 0;
   int   cycles = 0;
   bit   done   = 1'b0;

   always #2 clk = ~clk;

   dma_gctl #(.NUM_CH(NCH)) dut (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .nmi_evt(nmi_evt),
      .addr_err_evt(addr_err_evt), .ch_de(ch_de), .ch_te(ch_te),
      .ch_permit(ch_permit), .dma_suspend(dma_suspend)
   );

   // monitor: compares queued expectations away from the active edge
   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_chk++;
         if (rd_data !== e.rd || ch_permit !== e.perm || dma_suspend !== e.susp) begin
            n_fail++;
            $display("FAIL %s: rd=%b perm=%b susp=%b expected rd=%b perm=%b susp=%b",
                     e.tag, rd_data, ch_permit, dma_suspend, e.rd, e.perm, e.susp);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000 && !done) begin
         n_fail++;
         $display("FAIL watchdog: cycles=%0d expected completion", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_st(logic [2:0] r, logic [NCH-1:0] p, logic s, string tag);
      exp_t e;
      e.rd = r; e.perm = p; e.susp = s; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic do_write(logic [2:0] d);
      wr_en = 1'b1; wr_data = d;
      tick();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic do_read();
      rd_en = 1'b1;
      tick();
      rd_en = 1'b0;
   endtask

   task automatic pulse_nmi();
      nmi_evt = 1'b1;
      tick();
      nmi_evt = 1'b0;
   endtask

   task automatic pulse_aerr();
      addr_err_evt = 1'b1;
      tick();
      addr_err_evt = 1'b0;
   endtask

   initial begin
      repeat (3) tick();
      expect_st(3'b000, 4'b0000, 1'b1, "R1 in reset");
      rst_n = 1'b1;
      tick();
      expect_st(3'b000, 4'b0000, 1'b1, "R1 after reset");

      ch_de = 4'b1111; ch_te = 4'b0000;
      tick();
      expect_st(3'b000, 4'b0000, 1'b1, "R8 run off blocks");

      do_write(3'b001);
      expect_st(3'b001, 4'b0000, 1'b0, "R2 R7 run set");
      tick();
      expect_st(3'b001, 4'b1111, 1'b0, "R8 one-cycle permit");

      ch_de = 4'b1011; ch_te = 4'b0010;
      tick();
      expect_st(3'b001, 4'b1001, 1'b0, "R8 de/te mask");

      pulse_nmi();
      expect_st(3'b011, 4'b1001, 1'b1, "R3 nmi set");
      tick();
      expect_st(3'b011, 4'b0000, 1'b1, "R7 nmi suspends");

      do_write(3'b001);
      expect_st(3'b011, 4'b0000, 1'b1, "R5 no arm no clear");

      do_read();
      do_write(3'b001);
      expect_st(3'b001, 4'b0000, 1'b0, "R5 armed clear");
      tick();
      expect_st(3'b001, 4'b1001, 1'b0, "R8 resume");

      do_write(3'b011);
      expect_st(3'b001, 4'b1001, 1'b0, "R4 write1 nmi");
      do_write(3'b111);
      expect_st(3'b001, 4'b1001, 1'b0, "R4 write1 both");

      pulse_aerr();
      expect_st(3'b101, 4'b1001, 1'b1, "R6 aerr set");
      tick();
      expect_st(3'b101, 4'b0000, 1'b1, "R7 aerr suspends");

      do_read();
      addr_err_evt = 1'b1;
      do_write(3'b001);
      addr_err_evt = 1'b0;
      expect_st(3'b101, 4'b0000, 1'b1, "R6 event beats clear");
      do_write(3'b001);
      expect_st(3'b101, 4'b0000, 1'b1, "R5 arm consumed");
      do_read();
      do_write(3'b001);
      expect_st(3'b001, 4'b0000, 1'b0, "R6 aerr cleared");
      tick();
      expect_st(3'b001, 4'b1001, 1'b0, "R8 resume after aerr");

      pulse_nmi();
      expect_st(3'b011, 4'b1001, 1'b1, "R3 nmi again");
      do_read();
      expect_st(3'b011, 4'b0000, 1'b1, "R8 permit drops");
      do_write(3'b011);
      expect_st(3'b011, 4'b0000, 1'b1, "R5 write1 consumes arm");
      do_write(3'b001);
      expect_st(3'b011, 4'b0000, 1'b1, "R5 stale arm");
      do_read();
      do_write(3'b001);
      expect_st(3'b001, 4'b0000, 1'b0, "R5 rearmed clear");
      tick();
      expect_st(3'b001, 4'b1001, 1'b0, "R8 permit back");

      do_write(3'b000);
      expect_st(3'b000, 4'b1001, 1'b1, "R7 run cleared");
      tick();
      expect_st(3'b000, 4'b0000, 1'b1, "R8 run cleared");

      pulse_nmi();
      expect_st(3'b010, 4'b0000, 1'b1, "R3 nmi while idle");

      tick();
      tick();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule